// File: doc/BRIEF.md
# Countdown Timer with APB Register Port

A single-channel down-counting timer for a peripheral bus. Software programs a reload value and a control word over an APB slave port. Once the enable bit is set, the counter takes the reload value and then counts down by one on every clock. When it reaches zero it raises a sticky event flag and restarts. In periodic mode it restarts from the reload value. In free-running mode it restarts from all ones. Inverting the live count therefore gives software a rising time base.

The event flag is always recorded. A mask bit in the control word only decides whether the flag reaches the interrupt pin and the masked status views. Software acknowledges an event by reading either of two acknowledge offsets. The read itself clears the flag, so no write is needed. A fixed identification word and a raw status view sit in a small upper group of offsets. The port always completes in one access phase and never reports an error.

Top module: `cdt_timer`

## Requirements
- R1: After synchronous reset the reload value, the live count, the control word and the event flag are all 0, and `irq` is low.
- R2: `pready` is always 1 and `pslverr` is always 0. A write takes effect at the clock edge that ends its access phase. Read data is valid during the access phase.
- R3: Offset 0x00 holds the reload value (read/write). Offset 0x04 returns the live count (read-only). Offset 0x08 holds the control word in bits [2:0] (read/write, upper bits read 0): bit 0 is enable, bit 1 selects periodic (1) or free-running (0), and bit 2 is the mask. Offset 0xAC returns the parameter `VERSION`. Writes to read-only offsets change nothing. Reads of unmapped offsets return 0.
- R4: When a write changes enable from 0 to 1, the live count equals the reload value one cycle after that write's edge. It then drops by exactly one per clock. Rewriting the control word while enable stays 1 does not reload.
- R5: While enable is 0 the live count holds its value, no reload happens and the event flag is not set.
- R6: In periodic mode, on the cycle after an enabled counter reads 0, it reloads the reload value and sets the event flag. The event period is therefore reload+1 cycles.
- R7: In free-running mode, on the cycle after an enabled counter reads 0, it becomes 0xFFFF_FFFF and sets the event flag.
- R8: The event flag is set whatever the mask bit. Offset 0xA8 returns it in bit 0.
- R9: `irq` equals the event flag with the mask applied: low whenever the mask is 1. Offsets 0x10 and 0xA0 both return this masked value in bit 0.
- R10: A read of offset 0x0C or 0xA4 returns 0 and clears the event flag at the edge that ends the access. If a new event occurs on that same edge, the new event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte offset |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, combinational during a read |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq | output | 1 | Masked timer event |

## Verification
Read data depends only on the registers and the current address, so it is sampled during the access phase itself. Register writes become visible in the cycle after the access edge. A rising enable loads the counter one further cycle later. The event flag and `irq` rise reload+1 cycles after that load and stay up until an acknowledge read. The bench drives every access from a falling edge and samples a quarter period later. The driver queues each expected read value and the access-phase monitor pops and compares it, so every expected count is computed from the number of falling edges elapsed since the enabling write.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam logic [7:0] OFF_RELOAD  = 8'h00;
    localparam logic [7:0] OFF_LIVE    = 8'h04;
    localparam logic [7:0] OFF_CTRL    = 8'h08;
    localparam logic [7:0] OFF_ACK     = 8'h0C;
    localparam logic [7:0] OFF_MSTAT   = 8'h10;
    localparam logic [7:0] OFF_GMSTAT  = 8'hA0;
    localparam logic [7:0] OFF_GACK    = 8'hA4;
    localparam logic [7:0] OFF_RAW     = 8'hA8;
    localparam logic [7:0] OFF_IDENT   = 8'hAC;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_RELOAD,
        SEL_LIVE,
        SEL_CTRL,
        SEL_ACK,
        SEL_MSTAT,
        SEL_GMSTAT,
        SEL_GACK,
        SEL_RAW,
        SEL_IDENT
    } reg_sel_e;

    // enable is bit 0, periodic bit 1, mask bit 2
    typedef struct packed {
        logic mask;
        logic periodic;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic reg_sel_e sel_of(input logic [7:0] off);
        case (off)
            OFF_RELOAD: return SEL_RELOAD;
            OFF_LIVE:   return SEL_LIVE;
            OFF_CTRL:   return SEL_CTRL;
            OFF_ACK:    return SEL_ACK;
            OFF_MSTAT:  return SEL_MSTAT;
            OFF_GMSTAT: return SEL_GMSTAT;
            OFF_GACK:   return SEL_GACK;
            OFF_RAW:    return SEL_RAW;
            OFF_IDENT:  return SEL_IDENT;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic is_ack(input reg_sel_e s);
        return (s == SEL_ACK) || (s == SEL_GACK);
    endfunction

endpackage

// File: rtl/cdt_apb_decode.sv
module cdt_apb_decode
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output reg_sel_e          sel,
    output logic              reload_we,
    output logic              ctrl_we,
    output logic              ack_rd
);
    logic     upper_ok;
    reg_sel_e raw_sel;
    logic     access;

    generate
        if (ADDR_W > 8) begin : g_wide
            assign upper_ok = (paddr[ADDR_W-1:8] == '0);
        end else begin : g_narrow
            assign upper_ok = 1'b1;
        end
    endgenerate

    assign raw_sel = sel_of(paddr[7:0]);
    assign sel     = upper_ok ? raw_sel : SEL_NONE;
    assign access  = psel && penable;

    assign reload_we = access && pwrite  && (sel == SEL_RELOAD);
    assign ctrl_we   = access && pwrite  && (sel == SEL_CTRL);
    assign ack_rd    = access && !pwrite && is_ack(sel);
endmodule

// File: rtl/cdt_cfg_regs.sv
module cdt_cfg_regs
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload_we,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  reload_q,
    output ctrl_t             ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            ctrl_q   <= '0;
        end else begin
            if (reload_we) reload_q <= wdata[CNT_W-1:0];
            if (ctrl_we)   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end
endmodule

// File: rtl/cdt_count_core.sv
module cdt_count_core
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] reload,
    input  logic             ack_rd,
    output logic [CNT_W-1:0] count_q,
    output logic             en_prev_q,
    output logic             flag_q
);
    logic             start;
    logic             at_zero;
    logic [CNT_W-1:0] wrap_val;

    assign start    = ctrl.enable && !en_prev_q;
    assign at_zero  = ctrl.enable && en_prev_q && (count_q == '0);
    assign wrap_val = ctrl.periodic ? reload : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            en_prev_q <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            en_prev_q <= ctrl.enable;
            if (start)
                count_q <= reload;
            else if (at_zero)
                count_q <= wrap_val;
            else if (ctrl.enable)
                count_q <= count_q - 1'b1;

            // a new event on the acknowledge edge takes priority
            if (at_zero)
                flag_q <= 1'b1;
            else if (ack_rd)
                flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 32,
    parameter int          CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h0001_0203
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq
);
    localparam int PAD_W = DATA_W - CNT_W;

    reg_sel_e          sel;
    logic              reload_we;
    logic              ctrl_we;
    logic              ack_rd;
    logic [CNT_W-1:0]  reload_q;
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  count_q;
    logic              en_prev_q;
    logic              flag_q;
    logic              masked;
    logic [DATA_W-1:0] live_ext;
    logic [DATA_W-1:0] reload_ext;

    cdt_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .sel       (sel),
        .reload_we (reload_we),
        .ctrl_we   (ctrl_we),
        .ack_rd    (ack_rd)
    );

    cdt_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .reload_we (reload_we),
        .ctrl_we   (ctrl_we),
        .wdata     (pwdata),
        .reload_q  (reload_q),
        .ctrl_q    (ctrl_q)
    );

    cdt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .reload    (reload_q),
        .ack_rd    (ack_rd),
        .count_q   (count_q),
        .en_prev_q (en_prev_q),
        .flag_q    (flag_q)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign live_ext   = {{PAD_W{1'b0}}, count_q};
            assign reload_ext = {{PAD_W{1'b0}}, reload_q};
        end else begin : g_full
            assign live_ext   = count_q[DATA_W-1:0];
            assign reload_ext = reload_q[DATA_W-1:0];
        end
    endgenerate

    assign masked  = flag_q && !ctrl_q.mask;
    assign irq     = masked;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                SEL_RELOAD: prdata = reload_ext;
                SEL_LIVE:   prdata = live_ext;
                SEL_CTRL:   prdata = DATA_W'(ctrl_q);
                SEL_MSTAT,
                SEL_GMSTAT: prdata = DATA_W'(masked);
                SEL_RAW:    prdata = DATA_W'(flag_q);
                SEL_IDENT:  prdata = DATA_W'(VERSION);
                default:    prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              pready,
    input logic              pslverr,
    input logic              irq,
    input ctrl_t             ctrl_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  count_q,
    input logic              en_prev_q,
    input logic              flag_q
);
    logic rd_ack;
    logic wraps;

    assign rd_ack = psel && penable && !pwrite &&
                    ((paddr == ADDR_W'(OFF_ACK)) || (paddr == ADDR_W'(OFF_GACK)));
    assign wraps  = ctrl_q.enable && en_prev_q && (count_q == '0);

    a_r2_port_fixed: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr);

    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.enable && en_prev_q && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.enable) |=> (count_q == $past(count_q)));

    a_r5_no_new_flag: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.enable && !flag_q) |=> !flag_q);

    a_r6_periodic_wrap: assert property (@(posedge clk) disable iff (rst)
        (wraps && ctrl_q.periodic) |=> (count_q == $past(reload_q)) && flag_q);

    a_r7_free_wrap: assert property (@(posedge clk) disable iff (rst)
        (wraps && !ctrl_q.periodic) |=> (&count_q) && flag_q);

    a_r9_mask_quiet: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.mask |-> !irq);

    a_r10_ack_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !wraps) |=> !flag_q);
endmodule

bind cdt_timer cdt_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pready    (pready),
    .pslverr   (pslverr),
    .irq       (irq),
    .ctrl_q    (ctrl_q),
    .reload_q  (reload_q),
    .count_q   (count_q),
    .en_prev_q (en_prev_q),
    .flag_q    (flag_q)
);

// File: tb/test_cdt_timer.sv
module test_cdt_timer;
    localparam int          CLK_P = 10;
    localparam logic [31:0] VER   = 32'h0001_0203;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0]  q_addr[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #(CLK_P/2) clk = ~clk;

    cdt_timer #(.VERSION(VER)) i_cdt_timer (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .irq(irq)
    );

    // monitor: compares each read in its access phase against the queue head
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (psel && penable && !pwrite) begin
            total++;
            if (q_exp.size() == 0) begin
                bad++;
                $display("FAIL unexpected read addr=%h actual=%h expected=none", paddr, prdata);
            end else begin
                logic [7:0]  a;
                logic [31:0] e;
                string       t;
                a = q_addr.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (prdata !== e || paddr !== a) begin
                    bad++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", t, paddr, prdata, e);
                end
            end
        end
    end

    // all tasks start at a falling edge and return at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        q_addr.push_back(a);
        q_exp.push_back(e);
        q_tag.push_back(t);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic chk_pin(input logic act, input logic e, input string t);
        #(CLK_P/4);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", t, act, e);
        end
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        #(CLK_P/4);
        total++;
        if (irq !== e) begin
            bad++;
            $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        chk_irq(1'b0, "R1");
        chk_pin(pready, 1'b1, "R2 pready");
        chk_pin(pslverr, 1'b0, "R2 pslverr");
        rd(8'h00, 32'h0, "R1 reload");
        rd(8'h04, 32'h0, "R1 live");
        rd(8'h08, 32'h0, "R1 ctrl");
        rd(8'hA8, 32'h0, "R1 raw");
        rd(8'hAC, VER,   "R3 ident");
        rd(8'h14, 32'h0, "R3 unmapped");
        rd(8'h10, 32'h0, "R1 status");

        // read-only offsets ignore writes
        wr(8'h04, 32'h0000_1234);
        rd(8'h04, 32'h0, "R3 live ro");
        wr(8'hAC, 32'hFFFF_FFFF);
        rd(8'hAC, VER,   "R3 ident ro");

        // periodic, reload 3
        wr(8'h00, 32'd3);
        wr(8'h08, 32'h2);
        rd(8'h08, 32'h2, "R3 ctrl readback");
        rd(8'h00, 32'd3, "R3 reload readback");
        rd(8'h04, 32'h0, "R5 disabled no load");
        wr(8'h08, 32'h3);
        repeat (4) @(negedge clk);
        chk_irq(1'b0, "R6 before event");
        chk_irq(1'b1, "R6 event period");
        rd(8'h04, 32'd1, "R6 periodic reload");
        rd(8'h10, 32'h1, "R9 masked status");
        wr(8'h08, 32'h2);
        rd(8'h04, 32'h0, "R5 stop");
        rd(8'h04, 32'h0, "R5 hold");
        rd(8'h0C, 32'h0, "R10 ack returns 0");
        rd(8'hA8, 32'h0, "R10 ack clears");
        chk_irq(1'b0, "R10 irq low");

        // free-running, masked, reload 2
        wr(8'h00, 32'd2);
        wr(8'h08, 32'h5);
        rd(8'h04, 32'd2, "R4 load on enable");
        rd(8'h04, 32'd0, "R4 decrement");
        rd(8'hA8, 32'h1, "R8 raw despite mask");
        rd(8'h04, 32'hFFFF_FFFC, "R7 free wrap");
        rd(8'h10, 32'h0, "R9 status masked");
        rd(8'hA0, 32'h0, "R9 global masked");
        chk_irq(1'b0, "R9 irq masked");
        rd(8'hA4, 32'h0, "R10 global ack");
        rd(8'hA8, 32'h0, "R10 global ack clears");
        wr(8'h08, 32'h1);
        rd(8'h04, 32'hFFFF_FFEF, "R4 no reload on rewrite");
        chk_irq(1'b0, "R9 unmasked no event");

        repeat (2) @(negedge clk);
        if (q_exp.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R2 reads missing actual=%0d expected=0", q_exp.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule